// File: doc/BRIEF.md
# Status Register and Write-Protection Controller

This block is the write-control core of a serial flash device. It keeps the 8-bit status byte and acts on decoded instruction strobes from the serial front end. Those instructions set and clear the write-enable latch, open and write the status byte, and request byte or word programming or an erase. For each program request it decides whether the write may go ahead. That decision combines the write-enable latch, the busy state, the block-protect level and the write-protect pin level.

Erases run inside the block as self-timed operations. A sector, either block size or the whole array is walked one byte per clock on a write port that always carries FFh, while BUSY stays high for a parameterised number of clocks. Programming itself is sequenced elsewhere. That sequencer reports back through a busy level, a byte-done pulse and an end-of-word-session pulse.

Top module: `sr_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 1Ch (protect level bits 2..4 set, all other bits 0), `prog_grant` and `er_we` are 0.
- R2: Opcode 06h sets the write-enable bit (bit 1); opcode 04h clears the write-enable bit and the word-session bit (bit 6).
- R3: Opcode 01h writes data bits 7 and 5..2 into the status byte only when the strobe just before it carried 50h or 06h; any other strobe in between disarms it; data bits 0, 1 and 6 are never written; an armed 01h always clears the write-enable bit.
- R4: With `wp_n` low and bit 7 (lock) at 1, an armed 01h leaves bits 7..2 unchanged; with `wp_n` low and lock 0, lock may be set to 1; with `wp_n` high, lock has no effect and can be cleared.
- R5: The protected range follows bits 4..2 as a level L: L=0 protects nothing, L=1 the top 1/16 of the array, L=2 the top 1/8, L=3 the top 1/4, L=4..7 everything; bit 5 does not affect this range.
- R6: Opcodes 02h and ADh raise `prog_grant` for one cycle, the cycle after the strobe, exactly when the write-enable bit is 1, the device is not busy and `cmd_addr` is unprotected; a granted ADh also sets bit 6.
- R7: With the write-enable bit at 0, program and erase opcodes raise neither `prog_grant` nor BUSY.
- R8: Opcodes 20h, 52h and D8h erase the aligned region of 2^SECT_W, 2^B32_W and 2^B64_W bytes that contains `cmd_addr`: `er_we` is high for exactly one cycle per byte, addresses ascend from the region base, and `er_wdata` is FFh. The erase is ignored when the region's last byte is protected.
- R9: Opcodes 60h and C7h erase the whole array, but only when status bits 5..2 are all 0.
- R10: Status bit 0 (BUSY) rises the cycle after an accepted erase strobe and stays high for exactly the erase kind's duration parameter in clocks; it is also 1 whenever `ext_busy` is 1.
- R11: The write-enable bit clears when an erase finishes and on a `byte_done` pulse; an `aai_end` pulse clears both the write-enable bit and bit 6.
- R12: While BUSY is 1 every strobe except 04h is ignored; while bit 6 is 1 only ADh and 04h act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle strobe of a completed instruction |
| cmd_op | input | 8 | Instruction opcode |
| cmd_addr | input | ADDR_W | Instruction byte address |
| cmd_wdata | input | 8 | Data byte for status writes |
| wp_n | input | 1 | Write-protect pin level, active low |
| ext_busy | input | 1 | Program operation in progress in the array sequencer |
| byte_done | input | 1 | Pulse: a single-byte program has completed |
| aai_end | input | 1 | Pulse: a word-program session has ended |
| status_o | output | 8 | Status byte |
| prog_grant | output | 1 | Pulse: program request accepted |
| er_we | output | 1 | Erase write enable to the array |
| er_addr | output | ADDR_W | Erase write address |
| er_wdata | output | 8 | Erase write data (FFh) |

## Verification
The bench builds the block with a 256-byte array, 8-byte sectors, 32- and 64-byte blocks, and erase durations of 12, 40, 70 and 300 clocks. At that size every one of the 16 protect-field values can be swept against all 256 addresses for program grants. Every erase, including a full-array one, can also be followed byte by byte. The small durations also let the bench count the exact BUSY length of each kind, and the fractions 1/16, 1/8 and 1/4 still map onto whole sector and block boundaries.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_EWSR   = 8'h50;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_BPROG  = 8'h02;
  localparam logic [7:0] OP_AAI    = 8'hAD;
  localparam logic [7:0] OP_SECT   = 8'h20;
  localparam logic [7:0] OP_B32    = 8'h52;
  localparam logic [7:0] OP_B64    = 8'hD8;
  localparam logic [7:0] OP_CHIP_A = 8'h60;
  localparam logic [7:0] OP_CHIP_B = 8'hC7;

  typedef enum logic [1:0] {EK_SECT, EK_B32, EK_B64, EK_CHIP} ek_e;

  localparam logic [7:0] SR_RESET = 8'h1C;
endpackage

// File: rtl/sr_prot_map.sv
module sr_prot_map #(
  parameter int ADDR_W = 19
) (
  input  logic [2:0]        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int DEPTHS = 4;
  logic [DEPTHS:1] top_ones;

  genvar k;
  generate
    for (k = 1; k <= DEPTHS; k++) begin : g_top
      assign top_ones[k] = &addr[ADDR_W-1 -: k];
    end
  endgenerate

  always_comb begin
    case (lvl)
      3'd0:    hit = 1'b0;
      3'd1:    hit = top_ones[4];
      3'd2:    hit = top_ones[3];
      3'd3:    hit = top_ones[2];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_erase_eng.sv
module sr_erase_eng
  import sr_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECT_W   = 12,
  parameter int B32_W    = 15,
  parameter int B64_W    = 16,
  parameter int SECT_CYC = 5000,
  parameter int B32_CYC  = 40000,
  parameter int B64_CYC  = 80000,
  parameter int CHIP_CYC = 600000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  ek_e               kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              er_we,
  output logic [ADDR_W-1:0] er_addr
);
  localparam int MAX_AB = (SECT_CYC > B32_CYC) ? SECT_CYC : B32_CYC;
  localparam int MAX_CD = (B64_CYC > CHIP_CYC) ? B64_CYC : CHIP_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  localparam logic [ADDR_W-1:0] M_SECT = ADDR_W'((64'd1 << SECT_W) - 64'd1);
  localparam logic [ADDR_W-1:0] M_B32  = ADDR_W'((64'd1 << B32_W) - 64'd1);
  localparam logic [ADDR_W-1:0] M_B64  = ADDR_W'((64'd1 << B64_W) - 64'd1);
  localparam logic [ADDR_W-1:0] M_CHIP = {ADDR_W{1'b1}};

  logic [CW-1:0]     cnt_q, dur_sel;
  logic [ADDR_W-1:0] base_q, offs_q, mask_q, mask_sel;
  logic              fill_q;

  always_comb begin
    case (kind)
      EK_SECT: begin mask_sel = M_SECT; dur_sel = CW'(SECT_CYC); end
      EK_B32:  begin mask_sel = M_B32;  dur_sel = CW'(B32_CYC);  end
      EK_B64:  begin mask_sel = M_B64;  dur_sel = CW'(B64_CYC);  end
      default: begin mask_sel = M_CHIP; dur_sel = CW'(CHIP_CYC); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fill_q <= 1'b0;
      base_q <= '0;
      offs_q <= '0;
      mask_q <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q  <= dur_sel;
      fill_q <= 1'b1;
      base_q <= addr & ~mask_sel;
      offs_q <= '0;
      mask_q <= mask_sel;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (fill_q) begin
        if (offs_q == mask_q) fill_q <= 1'b0;
        else                  offs_q <= offs_q + 1'b1;
      end
    end
  end

  assign busy    = (cnt_q != '0);
  assign done    = (cnt_q == CW'(1));
  assign er_we   = fill_q;
  assign er_addr = base_q | offs_q;
endmodule

// File: rtl/sr_stat_regs.sv
module sr_stat_regs
  import sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       set_aai,
  input  logic       clr_aai,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       busy,
  output logic [7:0] status
);
  logic       wel_q, aai_q, lock_q;
  logic [3:0] bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= SR_RESET[1];
      aai_q  <= SR_RESET[6];
      lock_q <= SR_RESET[7];
      bp_q   <= SR_RESET[5:2];
    end else begin
      if (clr_wel)      wel_q <= 1'b0;
      else if (set_wel) wel_q <= 1'b1;
      if (clr_aai)      aai_q <= 1'b0;
      else if (set_aai) aai_q <= 1'b1;
      if (wr_en) begin
        bp_q   <= wr_data[5:2];
        lock_q <= wr_data[7];
      end
    end
  end

  assign status = {lock_q, aai_q, bp_q, wel_q, busy};
endmodule

// File: rtl/sr_wprot_ctrl.sv
module sr_wprot_ctrl
  import sr_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECT_W   = 12,
  parameter int B32_W    = 15,
  parameter int B64_W    = 16,
  parameter int SECT_CYC = 5000,
  parameter int B32_CYC  = 40000,
  parameter int B64_CYC  = 80000,
  parameter int CHIP_CYC = 600000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              ext_busy,
  input  logic              byte_done,
  input  logic              aai_end,
  output logic [7:0]        status_o,
  output logic              prog_grant,
  output logic              er_we,
  output logic [ADDR_W-1:0] er_addr,
  output logic [7:0]        er_wdata
);
  localparam logic [ADDR_W-1:0] M_SECT = ADDR_W'((64'd1 << SECT_W) - 64'd1);
  localparam logic [ADDR_W-1:0] M_B32  = ADDR_W'((64'd1 << B32_W) - 64'd1);
  localparam logic [ADDR_W-1:0] M_B64  = ADDR_W'((64'd1 << B64_W) - 64'd1);
  localparam int NPROBE = 2;

  logic [7:0]        sr;
  logic              eng_busy, eng_done, any_busy;
  logic              armed_q, grant_q;
  logic              live, wrsr_ok, wrsr_apply, prog_ok, er_cmd, er_ok;
  ek_e               er_kind;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W-1:0] probe [NPROBE];
  logic [NPROBE-1:0] prot;

  assign any_busy = eng_busy | ext_busy;

  // An instruction acts only outside BUSY and word sessions, except the
  // write-disable opcode which always acts and AD which continues a session.
  assign live = cmd_stb
              && (!any_busy || cmd_op == OP_WRDI)
              && (!sr[6] || cmd_op == OP_AAI || cmd_op == OP_WRDI);

  always_comb begin
    er_cmd  = 1'b0;
    er_kind = EK_SECT;
    case (cmd_op)
      OP_SECT:   begin er_cmd = 1'b1; er_kind = EK_SECT; end
      OP_B32:    begin er_cmd = 1'b1; er_kind = EK_B32;  end
      OP_B64:    begin er_cmd = 1'b1; er_kind = EK_B64;  end
      OP_CHIP_A: begin er_cmd = 1'b1; er_kind = EK_CHIP; end
      OP_CHIP_B: begin er_cmd = 1'b1; er_kind = EK_CHIP; end
      default:   ;
    endcase
  end

  always_comb begin
    case (er_kind)
      EK_SECT: end_addr = cmd_addr | M_SECT;
      EK_B32:  end_addr = cmd_addr | M_B32;
      EK_B64:  end_addr = cmd_addr | M_B64;
      default: end_addr = {ADDR_W{1'b1}};
    endcase
  end

  assign probe[0] = cmd_addr;
  assign probe[1] = end_addr;

  genvar p;
  generate
    for (p = 0; p < NPROBE; p++) begin : g_prot
      sr_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .lvl  (sr[4:2]),
        .addr (probe[p]),
        .hit  (prot[p])
      );
    end
  endgenerate

  assign wrsr_ok    = live && cmd_op == OP_WRSR && armed_q;
  assign wrsr_apply = wrsr_ok && !(!wp_n && sr[7]);
  assign prog_ok    = live && (cmd_op == OP_BPROG || cmd_op == OP_AAI)
                      && sr[1] && !prot[0];
  assign er_ok      = live && er_cmd && sr[1]
                      && ((er_kind == EK_CHIP) ? (sr[5:2] == 4'b0000) : !prot[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= prog_ok;
      if (cmd_stb) armed_q <= (cmd_op == OP_EWSR) || (cmd_op == OP_WREN);
    end
  end

  sr_erase_eng #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .B32_W(B32_W), .B64_W(B64_W),
    .SECT_CYC(SECT_CYC), .B32_CYC(B32_CYC), .B64_CYC(B64_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (er_ok),
    .kind    (er_kind),
    .addr    (cmd_addr),
    .busy    (eng_busy),
    .done    (eng_done),
    .er_we   (er_we),
    .er_addr (er_addr)
  );

  sr_stat_regs u_sr (
    .clk     (clk),
    .rst     (rst),
    .set_wel (live && cmd_op == OP_WREN),
    .clr_wel ((live && cmd_op == OP_WRDI) || wrsr_ok || eng_done || byte_done || aai_end),
    .set_aai (prog_ok && cmd_op == OP_AAI),
    .clr_aai ((live && cmd_op == OP_WRDI) || aai_end),
    .wr_en   (wrsr_apply),
    .wr_data (cmd_wdata),
    .busy    (any_busy),
    .status  (sr)
  );

  assign status_o   = sr;
  assign prog_grant = grant_q;
  assign er_wdata   = 8'hFF;
endmodule

// File: rtl/sr_wprot_chk.sv
module sr_wprot_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_stb,
  input logic              wp_n,
  input logic [7:0]        status_o,
  input logic              prog_grant,
  input logic              er_we,
  input logic [ADDR_W-1:0] er_addr
);
  // R8: erase addresses step by one while the write port stays active
  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    (er_we && $past(er_we)) |-> er_addr == $past(er_addr) + 1'b1);

  // R10: the erase port is only active while BUSY reads 1
  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    er_we |-> status_o[0]);

  // R7: a grant needs the write-enable bit one cycle before
  a_r7_grant_wel: assert property (@(posedge clk) disable iff (rst)
    prog_grant |-> $past(status_o[1]));

  // R4: lock cannot be released while the pin is low
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && status_o[7]) |=> status_o[7]);

  // R12: no strobe raises the write-enable bit while BUSY
  a_r12_busy_no_wel: assert property (@(posedge clk) disable iff (rst)
    (status_o[0] && cmd_stb) |=> !$rose(status_o[1]));
endmodule

bind sr_wprot_ctrl sr_wprot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_stb    (cmd_stb),
  .wp_n       (wp_n),
  .status_o   (status_o),
  .prog_grant (prog_grant),
  .er_we      (er_we),
  .er_addr    (er_addr)
);

// File: tb/sr_wprot_ctrl_tb.sv
module sr_wprot_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int SW   = 3;
  localparam int B32W = 5;
  localparam int B64W = 6;
  localparam int SCYC = 12;
  localparam int B32C = 40;
  localparam int B64C = 70;
  localparam int CCYC = 300;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_stb = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_wdata = '0;
  logic          wp_n = 1'b1;
  logic          ext_busy = 1'b0;
  logic          byte_done = 1'b0;
  logic          aai_end = 1'b0;
  logic [7:0]    status_o;
  logic          prog_grant;
  logic          er_we;
  logic [AW-1:0] er_addr;
  logic [7:0]    er_wdata;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_wprot_ctrl #(
    .ADDR_W(AW), .SECT_W(SW), .B32_W(B32W), .B64_W(B64W),
    .SECT_CYC(SCYC), .B32_CYC(B32C), .B64_CYC(B64C), .CHIP_CYC(CCYC)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .ext_busy(ext_busy), .byte_done(byte_done), .aai_end(aai_end),
    .status_o(status_o), .prog_grant(prog_grant), .er_we(er_we),
    .er_addr(er_addr), .er_wdata(er_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input int a, input logic [7:0] d);
    cmd_op = op; cmd_addr = AW'(a); cmd_wdata = d; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] d);
    send(8'h06, 0, 8'h00);
    send(8'h01, 0, d);
  endtask

  function automatic bit prot_exp(input int bp, input int a);
    int lv = bp & 7;
    if (lv == 0) return 1'b0;
    if (lv >= 4) return 1'b1;
    return a >= (256 - (256 >> (5 - lv)));
  endfunction

  task automatic do_erase(input logic [7:0] op, input int a, input bit run,
                          input int base, input int len, input int dur, input string tag);
    int bcnt = 0;
    int wcnt = 0;
    bit seq_ok = 1'b1;
    send(8'h06, 0, 8'h00);
    send(op, a, 8'h00);
    while (status_o[0] && bcnt < 2000) begin
      bcnt++;
      if (er_we) begin
        if (int'(er_addr) != base + wcnt || er_wdata != 8'hFF) seq_ok = 1'b0;
        wcnt++;
      end
      @(negedge clk);
    end
    if (run) begin
      chk(bcnt == dur, {tag, " R10 busy length"}, bcnt, dur);
      chk(wcnt == len, {tag, " R8 byte count"}, wcnt, len);
      chk(seq_ok, {tag, " R8 address order/FFh"}, 0, 1);
      chk(status_o[1] == 1'b0, {tag, " R11 WEL cleared at end"}, status_o[1], 0);
    end else begin
      chk(bcnt == 0 && wcnt == 0, {tag, " R8 protected erase ignored"}, bcnt, 0);
      send(8'h04, 0, 8'h00);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(status_o == 8'h1C, "R1 status", status_o, 8'h1C);
    chk(!prog_grant && !er_we, "R1 idle outputs", {prog_grant, er_we}, 0);

    // R2 enable/disable latch
    send(8'h06, 0, 8'h00);
    chk(status_o == 8'h1E, "R2 WREN", status_o, 8'h1E);
    send(8'h04, 0, 8'h00);
    chk(status_o == 8'h1C, "R2 WRDI", status_o, 8'h1C);

    // R3 arming
    send(8'h01, 0, 8'h00);
    chk(status_o == 8'h1C, "R3 unarmed write ignored", status_o, 8'h1C);
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h00);
    chk(status_o == 8'h00, "R3 armed by 50h", status_o, 8'h00);
    send(8'h50, 0, 8'h00); send(8'h04, 0, 8'h00); send(8'h01, 0, 8'h3C);
    chk(status_o == 8'h00, "R3 disarmed by other strobe", status_o, 8'h00);
    send(8'h06, 0, 8'h00); send(8'h01, 0, 8'hFF);
    chk(status_o == 8'hBC, "R3 armed by 06h, bits 0/1/6 kept, WEL cleared", status_o, 8'hBC);

    // R4 lock-down
    wp_n = 1'b0;
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h00);
    chk(status_o == 8'hBC, "R4 locked write ignored", status_o, 8'hBC);
    wp_n = 1'b1;
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h00);
    chk(status_o == 8'h00, "R4 pin high releases lock", status_o, 8'h00);
    wp_n = 1'b0;
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h80);
    chk(status_o == 8'h80, "R4 lock set with pin low", status_o, 8'h80);
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h00);
    chk(status_o == 8'h80, "R4 lock not cleared with pin low", status_o, 8'h80);
    wp_n = 1'b1;
    send(8'h50, 0, 8'h00); send(8'h01, 0, 8'h00);
    chk(status_o == 8'h00, "R4 cleared with pin high", status_o, 8'h00);

    // R5 / R6 sweep over every protect field value and address
    for (int v = 0; v < 16; v++) begin
      set_sr(8'(v << 2));
      chk(status_o == 8'(v << 2), "R5 field written", status_o, v << 2);
      for (int a = 0; a < 256; a++) begin
        send(8'h06, 0, 8'h00);
        send(8'h02, a, 8'h00);
        chk(prog_grant == !prot_exp(v, a), "R5 R6 program grant vs map",
            prog_grant, !prot_exp(v, a));
        send(8'h04, 0, 8'h00);
      end
    end

    // R7 no write enable
    set_sr(8'h00);
    send(8'h02, 0, 8'h00);
    chk(prog_grant == 1'b0, "R7 program without WEL", prog_grant, 0);
    send(8'h20, 0, 8'h00);
    chk(status_o[0] == 1'b0, "R7 erase without WEL", status_o[0], 0);

    // R11 byte completion
    send(8'h06, 0, 8'h00); send(8'h02, 5, 8'h00);
    chk(prog_grant == 1'b1, "R6 grant", prog_grant, 1);
    byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    chk(status_o == 8'h00, "R11 byte_done clears WEL", status_o, 8'h00);

    // R8 erases, level 0
    do_erase(8'h20, 8'h4D, 1'b1, 8'h48, 8, SCYC, "sect");
    do_erase(8'h52, 8'h77, 1'b1, 8'h60, 32, B32C, "b32");
    do_erase(8'hD8, 8'h9A, 1'b1, 8'h80, 64, B64C, "b64");
    // level 1: top 1/16
    set_sr(8'h04);
    do_erase(8'h20, 8'hF3, 1'b0, 0, 0, 0, "sect L1 top");
    do_erase(8'h20, 8'hE8, 1'b1, 8'hE8, 8, SCYC, "sect L1 below");
    do_erase(8'h52, 8'hE0, 1'b0, 0, 0, 0, "b32 L1");
    // level 3: top 1/4
    set_sr(8'h0C);
    do_erase(8'hD8, 8'h80, 1'b1, 8'h80, 64, B64C, "b64 L3 below");
    do_erase(8'hD8, 8'hC5, 1'b0, 0, 0, 0, "b64 L3 top");
    // R9 chip erase with only bit 5 set; bit 5 leaves range open (R5)
    set_sr(8'h20);
    do_erase(8'h60, 0, 1'b0, 0, 0, 0, "R9 chip blocked by bit5");
    do_erase(8'h20, 8'hF8, 1'b1, 8'hF8, 8, SCYC, "R5 bit5 ignored by range");
    set_sr(8'h00);
    do_erase(8'h60, 0, 1'b1, 0, 256, CCYC, "R9 chip 60h");
    do_erase(8'hC7, 8'h33, 1'b1, 0, 256, CCYC, "R9 chip C7h");

    // R10 external busy, R12 strobes while busy
    ext_busy = 1'b1; @(negedge clk);
    chk(status_o == 8'h01, "R10 ext_busy visible", status_o, 8'h01);
    send(8'h06, 0, 8'h00);
    chk(status_o == 8'h01, "R12 WREN ignored while busy", status_o, 8'h01);
    ext_busy = 1'b0; @(negedge clk);
    send(8'h06, 0, 8'h00); send(8'h20, 0, 8'h00);
    chk(status_o == 8'h03, "R10 busy after erase strobe", status_o, 8'h03);
    send(8'h04, 0, 8'h00);
    chk(status_o == 8'h01, "R12 WRDI acts while busy", status_o, 8'h01);
    send(8'h06, 0, 8'h00);
    chk(status_o == 8'h01, "R12 WREN still ignored", status_o, 8'h01);
    for (int i = 0; i < 50 && status_o[0]; i++) @(negedge clk);
    chk(status_o == 8'h00, "R10 busy ends", status_o, 8'h00);

    // R6 / R12 / R11 word session
    send(8'h06, 0, 8'h00); send(8'hAD, 8'h10, 8'h00);
    chk(prog_grant == 1'b1, "R6 AD grant", prog_grant, 1);
    chk(status_o == 8'h42, "R6 AD sets bit6", status_o, 8'h42);
    send(8'h20, 0, 8'h00);
    chk(status_o == 8'h42, "R12 erase ignored in session", status_o, 8'h42);
    send(8'hAD, 8'h12, 8'h00);
    chk(prog_grant == 1'b1, "R12 AD continues session", prog_grant, 1);
    aai_end = 1'b1; @(negedge clk); aai_end = 1'b0;
    chk(status_o == 8'h00, "R11 aai_end clears WEL and bit6", status_o, 8'h00);
    send(8'h06, 0, 8'h00); send(8'hAD, 8'h20, 8'h00); send(8'h04, 0, 8'h00);
    chk(status_o == 8'h00, "R2 WRDI ends session", status_o, 8'h00);

    summary();
    $finish;
  end
endmodule